// File: doc/BRIEF.md
# Phase-windowed clock selector

This block hands the output clock from one of two equal-frequency source clocks to the other without a glitch. The two sources come from a common master, so their frequency is the same. Their relative phase is unknown and can drift over a full period. A third, faster sampling clock watches the XOR of the two effective clocks. The XOR is high for a time that grows with the phase separation. When the separation drops under a quarter period (below 90 degrees or above 270 degrees), the block inverts whichever source is not driving the output. This keeps the two effective clocks between 90 and 270 degrees apart, so a later handover never sees two rising edges close together.

A handover begins with the select request. The request is resynchronised into the sampling domain and acted on only when no inversion is pending or settling. The new choice then crosses into each source domain through a short synchroniser. Each domain switches its own gate enable on the falling edge of its clock. The enable of the new source waits until the old one is seen off. Because of this, the output stays low from the old clock's fall until the new clock has gone low and then high. The `inv_mask` output shows which sources are currently inverted. `sw_done` shows that exactly the selected source is gating the output.

Top module: `cks_clock_selector`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low, `inv_mask` is 2'b00 and `sw_done` is 0.
- R2: After reset with `sel_req` low, source A (`clk_a`) drives `clk_out` and `sw_done` goes high within a few input periods.
- R3: The separation is measured by counting the samples in which the XOR of the two effective clocks is high, over windows of `SMP_PER_HALF` sample cycles (one input half-period). A count below half of `SMP_PER_HALF` is out of window and leads to inversion. A separation of exactly 90 or 270 degrees gives a count of exactly half and is left alone.
- R4: An inversion happens only after `AGREE` consecutive windows are out of window, and it flips one bit. Once the separation is back in the window, `inv_mask` stays unchanged.
- R5: `inv_mask` bit 0 set means source A is inverted, and bit 1 set means source B is inverted. Only the bit of the source that is not selected ever changes.
- R6: `sel_req` = 0 selects A and 1 selects B. After the handover, `clk_out` equals the selected source XOR its `inv_mask` bit, and `sw_done` is 1.
- R7: `clk_out` has no glitch. Every high phase lasts exactly half an input period, and no low phase is shorter than a quarter period. At most one source enable is active at a time, and an enable only rises while its clock is low.
- R8: A select change waits while an inversion is pending (at least one out-of-window result) and for `2*SMP_PER_HALF` sample cycles after an inversion. No inversion occurs while a handover is incomplete.
- R9: After an accepted select change, `sw_done` goes low within a few sample cycles. It stays low until only the newly selected source is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Source clock A |
| clk_b | input | 1 | Source clock B, same frequency as A, arbitrary phase |
| clk_smp | input | 1 | Sampling clock, `2*SMP_PER_HALF` times the source rate |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| sel_req | input | 1 | Source choice: 0 for A, 1 for B, asynchronous |
| clk_out | output | 1 | Gated output clock |
| inv_mask | output | 2 | Inversion applied to each source (bit 0 A, bit 1 B) |
| sw_done | output | 1 | Only the selected source is gating the output |

## Verification
The hardest case to reach from the ports is a select request that arrives while an inversion is still pending. If the hold-off works, the inversion lands on the old inactive source. If it does not, the switch goes first and the other source is inverted. To get there, the bench moves the inactive clock to zero separation, waits about one input period so that some out-of-window windows have been counted, and then raises the request. Which `inv_mask` bit ends up flipped tells the two orders apart. Sweeps of the inactive clock's phase across all eight eighth-period steps, first with each source active, cover both the inverting and the boundary cases.

// File: rtl/cks_pkg.sv
`timescale 1ns/1ps
package cks_pkg;
   typedef enum logic {
      SRC_A = 1'b0,
      SRC_B = 1'b1
   } cks_src_e;
endpackage

// File: rtl/cks_sync.sv
`timescale 1ns/1ps
// Multi-bit flop chain resynchroniser.
module cks_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cks_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("cks_sync: W must be at least 1");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/cks_gate_lane.sv
`timescale 1ns/1ps
// One source domain: synchronise the go-ahead, then update the gate on the falling edge.
module cks_gate_lane #(
   parameter int SYNC_STAGES = 2
) (
   input  logic cclk,
   input  logic rst_n,
   input  logic want,
   input  logic other_en,
   output logic en
);
   logic go;
   logic go_s;

   assign go = want & ~other_en;

   cks_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (cclk),
      .rst_n(rst_n),
      .d    (go),
      .q    (go_s)
   );

   always_ff @(negedge cclk or negedge rst_n) begin
      if (!rst_n) en <= 1'b0;
      else        en <= go_s;
   end
endmodule

// File: rtl/cks_phase_meter.sv
`timescale 1ns/1ps
// Sampling-domain control: phase window measurement, inversion, select arbitration.
module cks_phase_meter
   import cks_pkg::*;
#(
   parameter int SMP_PER_HALF = 4,
   parameter int AGREE        = 3,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       raw_a,
   input  logic       raw_b,
   input  logic       sel_req,
   input  logic [1:0] en,
   output logic [1:0] inv,
   output cks_src_e   sel_eff,
   output logic       done
);
   localparam int WCW     = $clog2(SMP_PER_HALF);
   localparam int HCW     = $clog2(SMP_PER_HALF + 1);
   localparam int SCW     = $clog2(AGREE + 1);
   localparam int GUARD   = 2 * SMP_PER_HALF;
   localparam int GCW     = $clog2(GUARD + 1);
   localparam int WIN_MIN = (SMP_PER_HALF + 1) / 2;

   if (SMP_PER_HALF < 2) begin : g_bad_rate
      $error("cks_phase_meter: sampling must be at least 4x the source rate");
   end
   if (AGREE < 1) begin : g_bad_agree
      $error("cks_phase_meter: AGREE must be at least 1");
   end

   logic [4:0] s_in, s_q;
   logic       a_s, b_s, req_s, ena_s, enb_s;

   assign s_in = {en[1], en[0], sel_req, raw_b, raw_a};

   cks_sync #(.W(5), .STAGES(SYNC_STAGES)) u_in_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (s_in),
      .q    (s_q)
   );

   assign a_s   = s_q[0];
   assign b_s   = s_q[1];
   assign req_s = s_q[2];
   assign ena_s = s_q[3];
   assign enb_s = s_q[4];

   logic [WCW-1:0] win_cnt;
   logic [HCW-1:0] hits, tally;
   logic [SCW-1:0] streak;
   logic [GCW-1:0] guard;
   logic [1:0]     inv_q;
   cks_src_e       sel_q;
   logic           x, win_end, out_win, done_c, done_q, inact_idx;

   assign x         = a_s ^ b_s ^ inv_q[0] ^ inv_q[1];
   assign tally     = hits + HCW'(x);
   assign win_end   = (win_cnt == WCW'(SMP_PER_HALF - 1));
   assign out_win   = (tally < HCW'(WIN_MIN));
   assign done_c    = (sel_q == SRC_B) ? (enb_s & ~ena_s) : (ena_s & ~enb_s);
   assign inact_idx = (sel_q == SRC_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt <= '0;
         hits    <= '0;
         streak  <= '0;
         guard   <= '0;
         inv_q   <= 2'b00;
         sel_q   <= SRC_A;
         done_q  <= 1'b0;
      end else begin
         if (win_end) begin
            win_cnt <= '0;
            hits    <= '0;
         end else begin
            win_cnt <= win_cnt + WCW'(1);
            hits    <= tally;
         end

         if (guard != '0) guard <= guard - GCW'(1);

         if (!done_c || guard != '0) begin
            streak <= '0;
         end else if (win_end) begin
            if (!out_win) begin
               streak <= '0;
            end else if (streak == SCW'(AGREE - 1)) begin
               streak           <= '0;
               guard            <= GCW'(GUARD);
               inv_q[inact_idx] <= ~inv_q[inact_idx];
            end else begin
               streak <= streak + SCW'(1);
            end
         end

         if (done_c && guard == '0 && streak == '0 && (req_s != (sel_q == SRC_B)))
            sel_q <= req_s ? SRC_B : SRC_A;

         done_q <= done_c;
      end
   end

   assign inv     = inv_q;
   assign sel_eff = sel_q;
   assign done    = done_q;

   a_r5_inactive_only: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_q != $past(inv_q)) |-> ((inv_q ^ $past(inv_q)) == ((sel_q == SRC_B) ? 2'b01 : 2'b10)));

   a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(inv_q ^ $past(inv_q)) <= 1);

   a_r8_no_flip_in_handover: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_q != $past(inv_q)) |-> $past(done_c));

   a_r8_hold_after_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_q != $past(inv_q)) |=> $stable(sel_q));
endmodule

// File: rtl/cks_clock_selector.sv
`timescale 1ns/1ps
// Top: two gated source lanes plus the sampling-domain controller.
module cks_clock_selector
   import cks_pkg::*;
#(
   parameter int SMP_PER_HALF = 4,
   parameter int AGREE        = 3,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk_a,
   input  logic       clk_b,
   input  logic       clk_smp,
   input  logic       rst_n,
   input  logic       sel_req,
   output logic       clk_out,
   output logic [1:0] inv_mask,
   output logic       sw_done
);
   localparam int NSRC = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cks_clock_selector: SYNC_STAGES must be at least 2");
   end

   logic [NSRC-1:0] raw, cclk, en, want;
   cks_src_e        sel_eff;

   assign raw  = {clk_b, clk_a};
   assign cclk = raw ^ inv_mask;
   assign want = {sel_eff == SRC_B, sel_eff == SRC_A};

   cks_phase_meter #(
      .SMP_PER_HALF(SMP_PER_HALF),
      .AGREE       (AGREE),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_meter (
      .clk    (clk_smp),
      .rst_n  (rst_n),
      .raw_a  (clk_a),
      .raw_b  (clk_b),
      .sel_req(sel_req),
      .en     (en),
      .inv    (inv_mask),
      .sel_eff(sel_eff),
      .done   (sw_done)
   );

   for (genvar i = 0; i < NSRC; i++) begin : g_lane
      cks_gate_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
         .cclk    (cclk[i]),
         .rst_n   (rst_n),
         .want    (want[i]),
         .other_en(en[NSRC-1-i]),
         .en      (en[i])
      );

      a_r7_rise_while_low: assert property (@(posedge clk_smp) disable iff (!rst_n)
         $rose(en[i]) |-> !cclk[i]);
   end

   assign clk_out = |(cclk & en);

   a_r7_one_lane: assert property (@(posedge clk_smp) disable iff (!rst_n)
      !(en[0] && en[1]));
endmodule

// File: tb/sim_cks_clock_selector.sv
`timescale 1ns/1ps
module sim_cks_clock_selector;
   localparam int TICK_NS    = 10;
   localparam int T_IN       = 8 * TICK_NS;
   localparam int SETTLE_SMP = 30 * 8;
   localparam int WD_NS      = 400000;

   logic clk_a = 1'b0, clk_b = 1'b0, clk_smp = 1'b0, rst_n = 1'b0, sel_req = 1'b0;
   logic       clk_out, sw_done;
   logic [1:0] inv_mask;

   cks_clock_selector u0 (
      .clk_a   (clk_a),
      .clk_b   (clk_b),
      .clk_smp (clk_smp),
      .rst_n   (rst_n),
      .sel_req (sel_req),
      .clk_out (clk_out),
      .inv_mask(inv_mask),
      .sw_done (sw_done)
   );

   int tick = 0, offa = 0, offb = 2;
   int checks = 0, errors = 0;

   // source clocks in eighth-period ticks, sampling edges halfway between ticks
   initial forever begin
      #(TICK_NS);
      tick++;
      clk_a = (((tick + 8 - offa) % 8) < 4);
      clk_b = (((tick + 8 - offb) % 8) < 4);
   end
   initial begin
      #(TICK_NS / 2);
      forever begin
         clk_smp = 1'b1; #(TICK_NS / 2);
         clk_smp = 1'b0; #(TICK_NS / 2);
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_ge(input string tag, input int act, input int lim);
      checks++;
      if (act < lim) begin
         errors++;
         $display("FAIL %s: actual %0d expected >= %0d", tag, act, lim);
      end
   endtask

   // reference model of the requirements
   logic [1:0] inv_e = 2'b00;
   int         src_e = 0;

   task automatic settle_model();
      int e, h;
      e = ((offb + 4 * int'(inv_e[1])) - (offa + 4 * int'(inv_e[0])) + 64) % 8;
      h = (e <= 4) ? e : 8 - e;
      if (h < 2) begin
         if (src_e == 0) inv_e[1] = ~inv_e[1];
         else            inv_e[0] = ~inv_e[0];
      end
   endtask

   // scoreboard
   string      q_tag[$];
   int         q_src[$];
   logic [1:0] q_inv[$];
   int         served = 0;

   task automatic push_exp(input string tag);
      int n;
      n = served;
      q_tag.push_back(tag);
      q_src.push_back(src_e);
      q_inv.push_back(inv_e);
      wait (served > n);
   endtask

   function automatic int eff_src(input int s, input logic [1:0] iv);
      return (s == 0) ? int'(clk_a ^ iv[0]) : int'(clk_b ^ iv[1]);
   endfunction

   initial forever begin
      wait (q_tag.size() != 0);
      repeat (SETTLE_SMP) @(posedge clk_smp);
      #2;
      check({q_tag[0], " inv_mask"}, int'(inv_mask), int'(q_inv[0]));
      check({q_tag[0], " sw_done"}, int'(sw_done), 1);
      for (int k = 0; k < 4; k++) begin
         check({q_tag[0], " clk_out follows source"}, int'(clk_out), eff_src(q_src[0], q_inv[0]));
         #(3 * TICK_NS);
      end
      void'(q_tag.pop_front());
      void'(q_src.pop_front());
      void'(q_inv.pop_front());
      served++;
   end

   // R7: pulse-width monitor on the output clock
   longint last_t = -1;
   always @(clk_out) begin
      if (!rst_n) begin
         last_t = -1;
      end else begin
         if (last_t >= 0) begin
            if (clk_out == 1'b0) check("R7 high phase width", int'($time - last_t), T_IN / 2);
            else                 check_ge("R7 low phase width", int'($time - last_t), T_IN / 4);
         end
         last_t = $time;
      end
   end

   initial begin
      #(WD_NS);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5 * 8) @(posedge clk_smp);
      #2;
      check("R1 clk_out in reset", int'(clk_out), 0);
      check("R1 inv_mask in reset", int'(inv_mask), 0);
      check("R1 sw_done in reset", int'(sw_done), 0);
      @(posedge clk_smp);
      #2;
      rst_n = 1'b1;

      settle_model();
      push_exp("R2 default source A");

      for (int o = 0; o < 8; o++) begin
         offb = o;
         settle_model();
         push_exp("R3 R5 sweep of inactive B");
      end
      push_exp("R4 no further flips once in window");

      sel_req = 1'b1;
      src_e   = 1;
      repeat (10) @(posedge clk_smp);
      #2;
      check("R9 sw_done low during handover", int'(sw_done), 0);
      settle_model();
      push_exp("R6 switch to B");

      for (int o = 0; o < 8; o++) begin
         offa = o;
         settle_model();
         push_exp("R3 R5 sweep of inactive A");
      end

      sel_req = 1'b0;
      src_e   = 0;
      settle_model();
      push_exp("R6 switch back to A");

      offb = (offa + 4 * int'(inv_e[0]) - 4 * int'(inv_e[1]) + 64) % 8;
      repeat (10) @(posedge clk_smp);
      #2;
      sel_req = 1'b1;
      settle_model();
      src_e = 1;
      settle_model();
      push_exp("R8 request held until inversion settles");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule